// File: doc/BRIEF.md
# ASID-Tagged TLB Lookup Unit

This block is a small, fully associative translation lookaside buffer for 4-Kbyte pages. Each entry holds a virtual page number, a physical page number, an 8-bit address-space tag, a shared flag and a valid bit. A lookup takes a 32-bit virtual address and a supervisor/user flag. One cycle later it reports a hit or a miss. On a hit it also gives the translated address: the physical page number with the page offset of the input address.

Software configures the block through a small register window. A base register, written through its own strobe, places a 64-Kbyte window. The window holds a control word and the current address-space tag. The control word has a translation enable and an address-space mode bit. In mode 0 the current tag is compared for every access. In mode 1 supervisor accesses always use tag 0x00 and user accesses use the current tag. This gives two levels of sharing for shared entries.

Entries are loaded through a write port into a round-robin victim slot. A flush input invalidates the whole array in one cycle.

Top module: `asid_tlb`

## Requirements
- R1: After reset the control word, the tag register and the base register read zero, all entries are invalid, the victim pointer is 0, and lk_hit and lk_miss are 0.
- R2: bar_q shows the base in bits 31:16 and the valid flag in bit 0; bits 15:1 read 0. Register accesses take effect only when the valid flag is set and reg_addr[31:16] equals the base. Offset 0x0000 selects the control word and offset 0x0004 selects the tag register (8 bits, zero-extended). reg_rdata holds the selected value one cycle after reg_re and 0 otherwise; undecoded accesses change nothing.
- R3: Control bit 0 is the translation enable and bit 1 is the address-space mode. Bits 31:2 are not stored and read 0.
- R4: With translation disabled, a lookup returns lk_hit=1, lk_miss=0 and lk_paddr equal to lk_vaddr, whatever the entries hold.
- R5: Results appear one cycle after lk_req. A hit requires a valid entry with vpn equal to lk_vaddr[31:12] and an accepted tag. lk_paddr is then {ppn, lk_vaddr[11:0]}. In a cycle with no request, lk_hit and lk_miss are 0.
- R6: In mode 0 an entry's tag must equal the tag register for user and supervisor accesses alike, unless the entry is shared.
- R7: In mode 1 a supervisor access accepts only entries whose tag is 0x00, shared or not.
- R8: In mode 1 a user access accepts a shared entry or an entry whose tag equals the tag register. A shared entry with a nonzero tag hits for users only; a shared entry with tag 0x00 hits for both.
- R9: Each entry write goes to the slot at the victim pointer. The pointer then advances by one and wraps from 7 to 0, so the ninth write replaces the first.
- R10: flush clears every valid bit in one cycle. A write in the same cycle is dropped and the pointer does not move.
- R11: When several entries match, the lowest-indexed one supplies the physical page.
- R12: With translation enabled, each request yields exactly one of lk_hit and lk_miss. On a miss lk_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bar_we | input | 1 | write strobe for the base register |
| bar_wdata | input | 32 | base (31:16) and valid flag (0) |
| bar_q | output | 32 | base register readback |
| reg_we | input | 1 | window register write strobe |
| reg_re | input | 1 | window register read strobe |
| reg_addr | input | 32 | window register address |
| reg_wdata | input | 32 | window register write data |
| reg_rdata | output | 32 | registered read data |
| ent_we | input | 1 | entry write strobe |
| ent_vpn | input | 20 | virtual page number |
| ent_ppn | input | 20 | physical page number |
| ent_asid | input | 8 | address-space tag |
| ent_shared | input | 1 | shared flag |
| ent_valid | input | 1 | valid bit for the written entry |
| flush | input | 1 | invalidate all entries |
| lk_req | input | 1 | lookup request strobe |
| lk_vaddr | input | 32 | virtual address |
| lk_super | input | 1 | 1 = supervisor access, 0 = user |
| lk_hit | output | 1 | registered hit |
| lk_miss | output | 1 | registered miss |
| lk_paddr | output | 32 | registered translated address |

## Verification
A wrong victim pointer shows at the next lookup of an overwritten or surviving page as a miss or hit that disagrees with the model. It stays visible until a flush. A stale valid bit after a flush shows as a hit on the very next lookup of that page. A wrong effective-tag choice shows only for particular combinations of mode, privilege, shared flag and zero tag. These combinations are covered by directed lookups and by random ones over a small page and tag space. Each result is compared one cycle after its request.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int ASID_W     = 8;
  localparam int VPN_W      = ADDR_W - PAGE_SHIFT;
  localparam int WIN_W      = 16;

  localparam logic [WIN_W-1:0] OFF_CTRL = 16'h0000;
  localparam logic [WIN_W-1:0] OFF_ASID = 16'h0004;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_regs.sv
module tlb_regs
  import asid_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bar_we,
  input  logic [ADDR_W-1:0] bar_wdata,
  output logic [ADDR_W-1:0] bar_q,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              virt_en,
  output logic              as_mode,
  output logic [ASID_W-1:0] asid_q
);
  logic [ADDR_W-WIN_W-1:0] base_q;
  logic                    base_v;
  logic                    sel;
  logic [WIN_W-1:0]        off;
  logic                    unused_bits;

  assign sel   = base_v && (reg_addr[ADDR_W-1:WIN_W] == base_q);
  assign off   = reg_addr[WIN_W-1:0];
  assign bar_q = {base_q, {(WIN_W-1){1'b0}}, base_v};
  assign unused_bits = ^{bar_wdata[WIN_W-1:1], reg_wdata[ADDR_W-1:ASID_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      base_v    <= 1'b0;
      virt_en   <= 1'b0;
      as_mode   <= 1'b0;
      asid_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (bar_we) begin
        base_q <= bar_wdata[ADDR_W-1:WIN_W];
        base_v <= bar_wdata[0];
      end
      if (reg_we && sel) begin
        if (off == OFF_CTRL) begin
          virt_en <= reg_wdata[0];
          as_mode <= reg_wdata[1];
        end else if (off == OFF_ASID) begin
          asid_q <= reg_wdata[ASID_W-1:0];
        end
      end
      reg_rdata <= '0;
      if (reg_re && sel) begin
        if (off == OFF_CTRL)
          reg_rdata <= {{(ADDR_W-2){1'b0}}, as_mode, virt_en};
        else if (off == OFF_ASID)
          reg_rdata <= {{(ADDR_W-ASID_W){1'b0}}, asid_q};
      end
    end
  end

  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_re) |-> reg_rdata == '0);
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_we) |-> $stable(virt_en) && $stable(as_mode));
  p_asid_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_we) |-> $stable(asid_q));
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import asid_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       we,
  input  tlb_entry_t wentry,
  output tlb_entry_t ent_q [NUM_ENTRIES]
);
  localparam int PTR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_ENTRIES - 1);

  logic [PTR_W-1:0]       ptr;
  logic [NUM_ENTRIES-1:0] vvec;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (!flush && we) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        ent_q[i].valid <= 1'b0;
      end else if (we && ptr == PTR_W'(i)) begin
        ent_q[i] <= wentry;
      end
    end
    assign vvec[i] = ent_q[i].valid;
  end

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> vvec == '0);
  p_rr_step_r9: assert property (@(posedge clk) disable iff (rst)
    $past(we && !flush) |-> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    $past(flush || !we) |-> $stable(ptr));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import asid_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
)(
  input  tlb_entry_t        ent [NUM_ENTRIES],
  input  logic [VPN_W-1:0]  vpn,
  input  logic              super_acc,
  input  logic              as_mode,
  input  logic [ASID_W-1:0] asid_reg,
  output logic              any_hit,
  output logic [VPN_W-1:0]  hit_ppn
);
  logic [NUM_ENTRIES-1:0] hit_vec;
  logic                   force_zero;
  logic [ASID_W-1:0]      eff_asid;

  assign force_zero = as_mode && super_acc;
  assign eff_asid   = force_zero ? '0 : asid_reg;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
    logic tag_ok;
    assign tag_ok     = (ent[i].shared && !force_zero) || (ent[i].asid == eff_asid);
    assign hit_vec[i] = ent[i].valid && (ent[i].vpn == vpn) && tag_ok;
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_ppn = ent[i].ppn;
    end
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        bar_we,
  input  logic [31:0] bar_wdata,
  output logic [31:0] bar_q,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [31:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ent_we,
  input  logic [19:0] ent_vpn,
  input  logic [19:0] ent_ppn,
  input  logic [7:0]  ent_asid,
  input  logic        ent_shared,
  input  logic        ent_valid,
  input  logic        flush,
  input  logic        lk_req,
  input  logic [31:0] lk_vaddr,
  input  logic        lk_super,
  output logic        lk_hit,
  output logic        lk_miss,
  output logic [31:0] lk_paddr
);
  logic              virt_en;
  logic              as_mode;
  logic [ASID_W-1:0] asid_q;
  tlb_entry_t        wentry;
  tlb_entry_t        ent_q [NUM_ENTRIES];
  logic              any_hit;
  logic [VPN_W-1:0]  hit_ppn;

  assign wentry = '{valid: ent_valid, shared: ent_shared, asid: ent_asid,
                    vpn: ent_vpn, ppn: ent_ppn};

  tlb_regs u_regs (
    .clk(clk), .rst(rst), .bar_we(bar_we), .bar_wdata(bar_wdata), .bar_q(bar_q),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .virt_en(virt_en), .as_mode(as_mode), .asid_q(asid_q)
  );

  tlb_entry_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_array (
    .clk(clk), .rst(rst), .flush(flush), .we(ent_we), .wentry(wentry), .ent_q(ent_q)
  );

  tlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .ent(ent_q), .vpn(lk_vaddr[ADDR_W-1:PAGE_SHIFT]), .super_acc(lk_super),
    .as_mode(as_mode), .asid_reg(asid_q), .any_hit(any_hit), .hit_ppn(hit_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit   <= 1'b0;
      lk_miss  <= 1'b0;
      lk_paddr <= '0;
    end else begin
      lk_hit  <= 1'b0;
      lk_miss <= 1'b0;
      if (lk_req) begin
        if (!virt_en) begin
          lk_hit   <= 1'b1;
          lk_paddr <= lk_vaddr;
        end else if (any_hit) begin
          lk_hit   <= 1'b1;
          lk_paddr <= {hit_ppn, lk_vaddr[PAGE_SHIFT-1:0]};
        end else begin
          lk_miss  <= 1'b1;
          lk_paddr <= '0;
        end
      end
    end
  end

  p_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss));
  p_answer_r12: assert property (@(posedge clk) disable iff (rst)
    $past(lk_req) |-> $countones({lk_hit, lk_miss}) == 1);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
    (lk_hit || lk_miss) |-> $past(lk_req));
  p_offset_kept_r5: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_paddr[PAGE_SHIFT-1:0] == $past(lk_vaddr[PAGE_SHIFT-1:0]));
  p_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    $past(lk_req && !virt_en) |-> lk_hit && lk_paddr == $past(lk_vaddr));
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bar_we = 0, reg_we = 0, reg_re = 0, ent_we = 0, flush = 0, lk_req = 0, lk_super = 0;
  logic [31:0] bar_wdata = 0, reg_addr = 0, reg_wdata = 0, lk_vaddr = 0;
  logic [19:0] ent_vpn = 0, ent_ppn = 0;
  logic [7:0]  ent_asid = 0;
  logic        ent_shared = 0, ent_valid = 0;
  logic [31:0] bar_q, reg_rdata, lk_paddr;
  logic        lk_hit, lk_miss;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst(rst), .bar_we(bar_we), .bar_wdata(bar_wdata), .bar_q(bar_q),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ent_we(ent_we), .ent_vpn(ent_vpn), .ent_ppn(ent_ppn),
    .ent_asid(ent_asid), .ent_shared(ent_shared), .ent_valid(ent_valid), .flush(flush),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_super(lk_super),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr)
  );

  // reference model
  logic        m_en = 0, m_mode = 0, m_bv = 0;
  logic [7:0]  m_asid = 0;
  logic [15:0] m_base = 0;
  logic        mv [8];
  logic        ms [8];
  logic [7:0]  ma [8];
  logic [19:0] mvpn [8];
  logic [19:0] mppn [8];
  int          mptr = 0;

  localparam logic [15:0] BASE = 16'hA5C0;
  localparam logic [31:0] A_CTRL = {BASE, 16'h0000};
  localparam logic [31:0] A_ASID = {BASE, 16'h0004};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [33:0] exp_lookup(input logic [31:0] va, input logic sup);
    if (!m_en) return {1'b1, 1'b0, va};
    for (int i = 0; i < 8; i++) begin
      logic ok;
      if (m_mode && sup) ok = (ma[i] == 8'h00);
      else               ok = ms[i] || (ma[i] == m_asid);
      if (mv[i] && mvpn[i] == va[31:12] && ok) return {1'b1, 1'b0, mppn[i], va[11:0]};
    end
    return {1'b0, 1'b1, 32'h0};
  endfunction

  function automatic logic decoded(input logic [31:0] a);
    return m_bv && (a[31:16] == m_base);
  endfunction

  task automatic bar_write(input logic [31:0] d);
    bar_we = 1; bar_wdata = d;
    @(negedge clk);
    bar_we = 0;
    m_base = d[31:16]; m_bv = d[0];
  endtask

  task automatic reg_write(input logic [31:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (decoded(a)) begin
      if (a[15:0] == 16'h0000) begin m_en = d[0]; m_mode = d[1]; end
      else if (a[15:0] == 16'h0004) m_asid = d[7:0];
    end
  endtask

  task automatic reg_read(input string tag, input logic [31:0] a);
    logic [31:0] e;
    e = 32'h0;
    if (decoded(a)) begin
      if (a[15:0] == 16'h0000) e = {30'h0, m_mode, m_en};
      else if (a[15:0] == 16'h0004) e = {24'h0, m_asid};
    end
    reg_re = 1; reg_addr = a;
    @(negedge clk);
    reg_re = 0;
    chk(tag, 64'(reg_rdata), 64'(e));
  endtask

  task automatic ent_write(input logic [19:0] vpn, input logic [19:0] ppn, input logic [7:0] asid,
                           input logic sh, input logic fl);
    ent_we = 1; ent_vpn = vpn; ent_ppn = ppn; ent_asid = asid; ent_shared = sh; ent_valid = 1;
    flush = fl;
    @(negedge clk);
    ent_we = 0; flush = 0;
    if (fl) begin
      for (int i = 0; i < 8; i++) mv[i] = 0;
    end else begin
      mv[mptr] = 1; ms[mptr] = sh; ma[mptr] = asid; mvpn[mptr] = vpn; mppn[mptr] = ppn;
      mptr = (mptr + 1) % 8;
    end
  endtask

  task automatic do_flush();
    flush = 1;
    @(negedge clk);
    flush = 0;
    for (int i = 0; i < 8; i++) mv[i] = 0;
  endtask

  task automatic lookup(input string tag, input logic [31:0] va, input logic sup);
    logic [33:0] e;
    e = exp_lookup(va, sup);
    lk_req = 1; lk_vaddr = va; lk_super = sup;
    @(negedge clk);
    lk_req = 0;
    chk(tag, {30'h0, lk_hit, lk_miss, lk_paddr}, {30'h0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mv[i] = 0; ms[i] = 0; ma[i] = 0; mvpn[i] = 0; mppn[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 hit/miss", {62'h0, lk_hit, lk_miss}, 64'h0);
    chk("R1 bar_q", 64'(bar_q), 64'h0);
    // R2 accesses ignored while base invalid
    reg_write(32'h0000_0000, 32'h3);
    reg_read("R2 read with base invalid", 32'h0000_0000);
    bar_write({BASE, 16'hFFFF});
    chk("R2 bar reserved bits", 64'(bar_q), 64'({BASE, 16'h0001}));
    reg_read("R1 ctrl after reset", A_CTRL);
    reg_read("R1 asid after reset", A_ASID);
    // R3 control bits
    reg_write(A_CTRL, 32'hFFFF_FFFC);
    reg_read("R3 reserved ctrl bits", A_CTRL);
    reg_write(A_CTRL, 32'hFFFF_FFFF);
    reg_read("R3 ctrl bits", A_CTRL);
    reg_write({16'hA5C1, 16'h0000}, 32'h0);
    reg_read("R2 wrong window ignored", A_CTRL);
    reg_write(A_CTRL, 32'h0);
    // R4 bypass
    lookup("R4 bypass", 32'h1234_5678, 1'b0);
    lookup("R4 bypass super", 32'hDEAD_BEEF, 1'b1);
    reg_write(A_CTRL, 32'h1);
    lookup("R1 entries invalid", 32'h1234_5678, 1'b0);
    // R5/R6 mode 0
    reg_write(A_ASID, 32'h3);
    reg_read("R2 asid read", A_ASID);
    ent_write(20'h12345, 20'hABCDE, 8'h03, 1'b0, 1'b0);
    lookup("R5 hit user", 32'h1234_5A5A, 1'b0);
    chk("R5 paddr", 64'(lk_paddr), 64'h0ABC_DEA5A);
    lookup("R6 hit super mode0", 32'h1234_5001, 1'b1);
    @(negedge clk);
    chk("R5 idle no result", {62'h0, lk_hit, lk_miss}, 64'h0);
    reg_write(A_ASID, 32'h4);
    lookup("R6 miss user other asid", 32'h1234_5000, 1'b0);
    lookup("R6 miss super other asid", 32'h1234_5000, 1'b1);
    ent_write(20'h00100, 20'h11111, 8'h07, 1'b1, 1'b0);
    lookup("R6 shared hit", 32'h0010_0123, 1'b1);
    // R7/R8 mode 1
    reg_write(A_CTRL, 32'h3);
    ent_write(20'h00200, 20'h22222, 8'h00, 1'b0, 1'b0);
    ent_write(20'h00300, 20'h33333, 8'h00, 1'b1, 1'b0);
    lookup("R7 super tag0 hit", 32'h0020_0010, 1'b1);
    lookup("R8 user tag0 unshared miss", 32'h0020_0010, 1'b0);
    reg_write(A_ASID, 32'h3);
    lookup("R7 super ignores tag reg", 32'h1234_5000, 1'b1);
    lookup("R8 user own tag hit", 32'h1234_5000, 1'b0);
    lookup("R8 shared nonzero user hit", 32'h0010_0000, 1'b0);
    lookup("R7 shared nonzero super miss", 32'h0010_0000, 1'b1);
    lookup("R8 shared zero user hit", 32'h0030_0444, 1'b0);
    lookup("R8 shared zero super hit", 32'h0030_0444, 1'b1);
    // R11 lowest index wins
    reg_write(A_CTRL, 32'h1);
    ent_write(20'h12345, 20'h55555, 8'h03, 1'b0, 1'b0);
    lookup("R11 lowest index", 32'h1234_5FFF, 1'b0);
    chk("R11 ppn", 64'(lk_paddr[31:12]), 64'hABCDE);
    // R10 flush
    do_flush();
    lookup("R10 flushed", 32'h1234_5000, 1'b0);
    ent_write(20'h00777, 20'h77777, 8'h03, 1'b0, 1'b1);
    lookup("R10 write dropped", 32'h0077_7000, 1'b0);
    // R9 round robin wrap
    for (int i = 0; i < 8; i++) ent_write(20'h00400 + 20'(i), 20'h40000 + 20'(i), 8'h03, 1'b0, 1'b0);
    ent_write(20'h00500, 20'h50000, 8'h03, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) lookup("R9 round robin", {20'h00400 + 20'(i), 12'h010}, 1'b0);
    lookup("R9 newest", 32'h0050_0000, 1'b0);
    // random phase
    void'($urandom(32'd1234));
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = $urandom_range(0, 15);
      if (op < 8)
        lookup("R5 R6 R7 R8 R11 R12 random", {20'($urandom_range(0, 15)), 12'($urandom)}, 1'($urandom));
      else if (op < 12)
        ent_write(20'($urandom_range(0, 15)), 20'($urandom), 8'($urandom_range(0, 3)), 1'($urandom), 1'b0);
      else if (op == 12)
        reg_write(A_CTRL, (32'($urandom_range(0, 7)) == 0) ? 32'h0 : 32'($urandom_range(1, 3) | 1));
      else if (op == 13)
        reg_write(A_ASID, 32'($urandom_range(0, 3)));
      else if (op == 14)
        reg_read("R2 random read", ($urandom_range(0, 1) == 1) ? A_ASID : A_CTRL);
      else if ($urandom_range(0, 3) == 0)
        do_flush();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule